// File: doc/BRIEF.md
# Special-Register Rename Dispatch Logic

This block sits in the dispatch stage of an out-of-order core and handles three renamed special registers: a condition-register field file (class 0), a link register (class 1) and a count register (class 2). For every slot of a dispatch group, each special-register source of a branch is looked up in the rename map. The source is then sent one of three ways. If it is not renamed, it is read from the architectural register. If it is renamed and its rename buffer already holds the value, the tag goes out on one of that class's limited rename-buffer read ports. If it is renamed and the value is still pending, only the tag is kept, and the reservation-station operand waits for the result broadcast.

At dispatch the block also hands out new link-register and count-register rename tags, from circular pools gated by a free count. Branches request these when they write those registers. Move-to-special-register instructions request them when their register-number field is 8 (link) or 9 (count). The block passes the reorder-buffer index through as the instruction tag and stamps every slot with a running branch counter. Slots dispatch strictly in order: the first slot whose read ports or free buffers run short stalls, and so does every slot after it. Decode, the rename map, rename-buffer storage and the reorder buffer drive plain inputs.

Top module: `sreg_dispatch`

## Requirements
- R1: A branch source in use whose map entry is not live gets source mode 1 (architectural). `arch_rd_o` is high for it, and it takes no read port. The done flag is ignored in this case.
- R2: A branch source in use whose map entry is live and done gets mode 2 (rename read). Its tag appears on `rd_tag_o` of that class at the port given by `src_port_o`, with `rd_vld_o` high. `arch_rd_o` stays low.
- R3: A branch source in use whose map entry is live but not done gets mode 3 (wait). `src_tag_o` carries the map tag, and neither an architectural read nor a port read is issued.
- R4: A source that is not in use, and any source of a non-branch slot (kind 0 other, kind 2 move-to-special), gets mode 0 and issues no read.
- R5: Each class (0 condition field, 1 link, 2 count) has its own RD_PORTS read ports. Within a class, ports are assigned in slot order starting at port 0.
- R6: A valid slot that needs a read port when none of its class is left is not dispatched, and neither is any later slot. Earlier slots still dispatch, and an invalid slot blocks nothing.
- R7: A branch with its link-write or count-write flag gets a destination tag for that register. Tags come consecutively from a per-register head, which advances by the number allocated. A destination that is not written has its valid flag low.
- R8: A move-to-special slot with register number 8 allocates a link tag, with 9 allocates a count tag, and with any other number allocates nothing.
- R9: A slot needing more link or count buffers than `free_lr_i`/`free_ctr_i` leave stalls itself and later slots. `alloc_lr_o`/`alloc_ctr_o` report the tags actually handed out.
- R10: Each slot's `bcnt_o` is the branch counter plus the number of dispatched branches in earlier slots. Dispatched branches advance the counter for the next cycle, and other kinds leave it unchanged.
- R11: `n_taken_o` counts dispatched branches predicted taken, and `n_other_o` counts all other dispatched slots.
- R12: `itag_vld_o` follows `rob_vld_i`, and `itag_o` carries `rob_idx_i`, for each slot.
- R13: After reset the branch counter and both allocation heads are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_vld_i | input | DISP_W | Slot holds an instruction |
| slot_kind_i | input | DISP_W x 2 | 0 other, 1 branch, 2 move-to-special |
| slot_taken_i | input | DISP_W | Branch predicted taken |
| src_use_i | input | DISP_W x 3 | Branch reads class c |
| wr_lr_i | input | DISP_W | Branch writes link register |
| wr_ctr_i | input | DISP_W | Branch writes count register |
| spr_num_i | input | DISP_W x SPR_W | Move-to-special register number |
| rob_vld_i | input | DISP_W | Reorder-buffer entry allocated |
| rob_idx_i | input | DISP_W x ROB_W | Reorder-buffer index |
| map_live_i | input | DISP_W x 3 | Source has a live rename tag |
| map_tag_i | input | DISP_W x 3 x TAG_W | Rename tag from the map |
| map_done_i | input | DISP_W x 3 | Rename buffer holds its value |
| free_lr_i | input | CNT_W | Free link rename buffers |
| free_ctr_i | input | CNT_W | Free count rename buffers |
| disp_o | output | DISP_W | Slot dispatched this cycle |
| src_mode_o | output | DISP_W x 3 x 2 | Source mode per class |
| src_tag_o | output | DISP_W x 3 x TAG_W | Tag kept in the station |
| src_port_o | output | DISP_W x 3 x PIDX_W | Read port carrying the operand |
| arch_rd_o | output | DISP_W x 3 | Architectural read request |
| rd_vld_o | output | 3 x RD_PORTS | Rename read port active |
| rd_tag_o | output | 3 x RD_PORTS x TAG_W | Rename read port tag |
| dst_lr_vld_o | output | DISP_W | Link destination allocated |
| dst_lr_tag_o | output | DISP_W x TAG_W | Link destination tag |
| dst_ctr_vld_o | output | DISP_W | Count destination allocated |
| dst_ctr_tag_o | output | DISP_W x TAG_W | Count destination tag |
| itag_vld_o | output | DISP_W | Instruction tag valid |
| itag_o | output | DISP_W x ROB_W | Instruction tag |
| bcnt_o | output | DISP_W x BCNT_W | Branch counter stamp |
| n_taken_o | output | CNT_W | Dispatched predicted-taken branches |
| n_other_o | output | CNT_W | Other dispatched slots |
| alloc_lr_o | output | CNT_W | Link tags allocated |
| alloc_ctr_o | output | CNT_W | Count tags allocated |

## Verification
A vector table sweeps the use, live and done flag combinations over all three classes and over every slot kind. This separates the architectural, rename-read, wait and none outcomes, and shows that the done flag matters only when the entry is live. Two slots competing for a single port of the same class tell an in-order stall apart from port sharing, while the same load spread over different classes shows that the port pools are independent. Free-count starvation, move-to-special register numbers inside and outside 8 and 9, an invalid leading slot and a taken/not-taken branch pair cover the allocation, stall and counting rules. A second reset shows that the branch counter and the allocation heads return to zero.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int NCLS    = 3;
  localparam int CLS_CR  = 0;
  localparam int CLS_LR  = 1;
  localparam int CLS_CTR = 2;
  localparam int SPR_LR_NUM  = 8;
  localparam int SPR_CTR_NUM = 9;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ARCH = 2'd1,
    SRC_RBUF = 2'd2,
    SRC_WAIT = 2'd3
  } src_mode_e;

  typedef enum logic [1:0] {
    K_OTHER  = 2'd0,
    K_BRANCH = 2'd1,
    K_MTSPR  = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/sreg_src_resolve.sv
module sreg_src_resolve
  import sreg_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             use_i,
  input  logic             live_i,
  input  logic             done_i,
  input  logic [TAG_W-1:0] tag_i,
  output src_mode_e        mode_o,
  output logic [TAG_W-1:0] tag_o
);
  always_comb begin
    mode_o = SRC_NONE;
    tag_o  = '0;
    if (use_i) begin
      if (!live_i) begin
        mode_o = SRC_ARCH;
      end else begin
        tag_o  = tag_i;
        mode_o = done_i ? SRC_RBUF : SRC_WAIT;
      end
    end
  end
endmodule

// File: rtl/sreg_slot_arb.sv
module sreg_slot_arb
  import sreg_pkg::*;
#(
  parameter int DISP_W   = 2,
  parameter int RD_PORTS = 1,
  parameter int CNT_W    = 2,
  parameter int PIDX_W   = 1
) (
  input  logic [DISP_W-1:0]                        vld_i,
  input  logic [DISP_W-1:0]                        br_i,
  input  logic [DISP_W-1:0]                        taken_i,
  input  logic [DISP_W-1:0][NCLS-1:0]              need_i,
  input  logic [DISP_W-1:0]                        want_lr_i,
  input  logic [DISP_W-1:0]                        want_ctr_i,
  input  logic [CNT_W-1:0]                         free_lr_i,
  input  logic [CNT_W-1:0]                         free_ctr_i,
  output logic [DISP_W-1:0]                        disp_o,
  output logic [DISP_W-1:0][NCLS-1:0][PIDX_W-1:0]  port_o,
  output logic [DISP_W-1:0][CNT_W-1:0]             lr_ofs_o,
  output logic [DISP_W-1:0][CNT_W-1:0]             ctr_ofs_o,
  output logic [DISP_W-1:0][CNT_W-1:0]             br_ofs_o,
  output logic [CNT_W-1:0]                         n_taken_o,
  output logic [CNT_W-1:0]                         n_other_o,
  output logic [CNT_W-1:0]                         n_lr_o,
  output logic [CNT_W-1:0]                         n_ctr_o,
  output logic [CNT_W-1:0]                         n_br_o
);
  int   pcnt [NCLS];
  int   lr_n, ctr_n, br_n, tk_n, ot_n;
  logic go, fit;

  // Running prefix over slots; once a valid slot misfits, all later slots hold.
  always_comb begin
    for (int c = 0; c < NCLS; c++) pcnt[c] = 0;
    lr_n = 0; ctr_n = 0; br_n = 0; tk_n = 0; ot_n = 0;
    go = 1'b1;
    fit = 1'b1;
    disp_o = '0; port_o = '0; lr_ofs_o = '0; ctr_ofs_o = '0; br_ofs_o = '0;
    for (int k = 0; k < DISP_W; k++) begin
      fit = 1'b1;
      for (int c = 0; c < NCLS; c++) begin
        if (need_i[k][c] && pcnt[c] >= RD_PORTS) fit = 1'b0;
        if (need_i[k][c] && pcnt[c] < RD_PORTS) port_o[k][c] = PIDX_W'(pcnt[c]);
      end
      if (want_lr_i[k]  && lr_n  >= int'(free_lr_i))  fit = 1'b0;
      if (want_ctr_i[k] && ctr_n >= int'(free_ctr_i)) fit = 1'b0;
      lr_ofs_o[k]  = CNT_W'(lr_n);
      ctr_ofs_o[k] = CNT_W'(ctr_n);
      br_ofs_o[k]  = CNT_W'(br_n);
      disp_o[k] = go && vld_i[k] && fit;
      if (disp_o[k]) begin
        for (int c = 0; c < NCLS; c++) if (need_i[k][c]) pcnt[c]++;
        if (want_lr_i[k])  lr_n++;
        if (want_ctr_i[k]) ctr_n++;
        if (br_i[k]) br_n++;
        if (br_i[k] && taken_i[k]) tk_n++;
        else ot_n++;
      end
      if (vld_i[k] && !fit) go = 1'b0;
    end
    n_taken_o = CNT_W'(tk_n);
    n_other_o = CNT_W'(ot_n);
    n_lr_o    = CNT_W'(lr_n);
    n_ctr_o   = CNT_W'(ctr_n);
    n_br_o    = CNT_W'(br_n);
  end
endmodule

// File: rtl/sreg_wrap_ctr.sv
module sreg_wrap_ctr #(
  parameter int W     = 3,
  parameter int ADV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADV_W-1:0] adv_i,
  output logic [W-1:0]     val_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_q + W'(adv_i);
  end

  assign val_o = val_q;
endmodule

// File: rtl/sreg_dispatch.sv
module sreg_dispatch
  import sreg_pkg::*;
#(
  parameter int DISP_W   = 2,
  parameter int RD_PORTS = 1,
  parameter int TAG_W    = 3,
  parameter int ROB_W    = 5,
  parameter int BCNT_W   = 4,
  parameter int SPR_W    = 10,
  localparam int CNT_W   = $clog2(DISP_W + 1),
  localparam int PIDX_W  = (RD_PORTS > 1) ? $clog2(RD_PORTS) : 1
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [DISP_W-1:0]                        slot_vld_i,
  input  logic [DISP_W-1:0][1:0]                   slot_kind_i,
  input  logic [DISP_W-1:0]                        slot_taken_i,
  input  logic [DISP_W-1:0][NCLS-1:0]              src_use_i,
  input  logic [DISP_W-1:0]                        wr_lr_i,
  input  logic [DISP_W-1:0]                        wr_ctr_i,
  input  logic [DISP_W-1:0][SPR_W-1:0]             spr_num_i,
  input  logic [DISP_W-1:0]                        rob_vld_i,
  input  logic [DISP_W-1:0][ROB_W-1:0]             rob_idx_i,
  input  logic [DISP_W-1:0][NCLS-1:0]              map_live_i,
  input  logic [DISP_W-1:0][NCLS-1:0][TAG_W-1:0]   map_tag_i,
  input  logic [DISP_W-1:0][NCLS-1:0]              map_done_i,
  input  logic [CNT_W-1:0]                         free_lr_i,
  input  logic [CNT_W-1:0]                         free_ctr_i,
  output logic [DISP_W-1:0]                        disp_o,
  output logic [DISP_W-1:0][NCLS-1:0][1:0]         src_mode_o,
  output logic [DISP_W-1:0][NCLS-1:0][TAG_W-1:0]   src_tag_o,
  output logic [DISP_W-1:0][NCLS-1:0][PIDX_W-1:0]  src_port_o,
  output logic [DISP_W-1:0][NCLS-1:0]              arch_rd_o,
  output logic [NCLS-1:0][RD_PORTS-1:0]            rd_vld_o,
  output logic [NCLS-1:0][RD_PORTS-1:0][TAG_W-1:0] rd_tag_o,
  output logic [DISP_W-1:0]                        dst_lr_vld_o,
  output logic [DISP_W-1:0][TAG_W-1:0]             dst_lr_tag_o,
  output logic [DISP_W-1:0]                        dst_ctr_vld_o,
  output logic [DISP_W-1:0][TAG_W-1:0]             dst_ctr_tag_o,
  output logic [DISP_W-1:0]                        itag_vld_o,
  output logic [DISP_W-1:0][ROB_W-1:0]             itag_o,
  output logic [DISP_W-1:0][BCNT_W-1:0]            bcnt_o,
  output logic [CNT_W-1:0]                         n_taken_o,
  output logic [CNT_W-1:0]                         n_other_o,
  output logic [CNT_W-1:0]                         alloc_lr_o,
  output logic [CNT_W-1:0]                         alloc_ctr_o
);
  logic [DISP_W-1:0]                       is_br, is_mt, want_lr, want_ctr;
  logic [DISP_W-1:0][NCLS-1:0]             use_eff, need;
  src_mode_e                               mode_w [DISP_W][NCLS];
  logic [DISP_W-1:0][NCLS-1:0][PIDX_W-1:0] port_w;
  logic [DISP_W-1:0][CNT_W-1:0]            lr_ofs, ctr_ofs, br_ofs;
  logic [CNT_W-1:0]                        n_br;
  logic [TAG_W-1:0]                        lr_head, ctr_head;
  logic [BCNT_W-1:0]                       bcnt_head;

  // Slot decode: only branches resolve special-register sources
  always_comb begin
    for (int k = 0; k < DISP_W; k++) begin
      is_br[k]    = slot_kind_i[k] == K_BRANCH;
      is_mt[k]    = slot_kind_i[k] == K_MTSPR;
      use_eff[k]  = src_use_i[k] & {NCLS{is_br[k]}};
      want_lr[k]  = (is_br[k] && wr_lr_i[k]) ||
                    (is_mt[k] && spr_num_i[k] == SPR_W'(SPR_LR_NUM));
      want_ctr[k] = (is_br[k] && wr_ctr_i[k]) ||
                    (is_mt[k] && spr_num_i[k] == SPR_W'(SPR_CTR_NUM));
    end
  end

  for (genvar k = 0; k < DISP_W; k++) begin : g_slot
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
      sreg_src_resolve #(.TAG_W(TAG_W)) i_res (
        .use_i  (use_eff[k][c]),
        .live_i (map_live_i[k][c]),
        .done_i (map_done_i[k][c]),
        .tag_i  (map_tag_i[k][c]),
        .mode_o (mode_w[k][c]),
        .tag_o  (src_tag_o[k][c])
      );
      assign src_mode_o[k][c] = mode_w[k][c];
      assign need[k][c]       = mode_w[k][c] == SRC_RBUF;
      assign arch_rd_o[k][c]  = disp_o[k] && mode_w[k][c] == SRC_ARCH;
      assign src_port_o[k][c] = port_w[k][c];
    end
    assign dst_lr_vld_o[k]  = disp_o[k] && want_lr[k];
    assign dst_ctr_vld_o[k] = disp_o[k] && want_ctr[k];
    assign dst_lr_tag_o[k]  = lr_head + TAG_W'(lr_ofs[k]);
    assign dst_ctr_tag_o[k] = ctr_head + TAG_W'(ctr_ofs[k]);
    assign bcnt_o[k]        = bcnt_head + BCNT_W'(br_ofs[k]);
    assign itag_vld_o[k]    = rob_vld_i[k];
    assign itag_o[k]        = rob_vld_i[k] ? rob_idx_i[k] : '0;
  end

  sreg_slot_arb #(
    .DISP_W(DISP_W), .RD_PORTS(RD_PORTS), .CNT_W(CNT_W), .PIDX_W(PIDX_W)
  ) i_arb (
    .vld_i      (slot_vld_i),
    .br_i       (is_br),
    .taken_i    (slot_taken_i),
    .need_i     (need),
    .want_lr_i  (want_lr),
    .want_ctr_i (want_ctr),
    .free_lr_i  (free_lr_i),
    .free_ctr_i (free_ctr_i),
    .disp_o     (disp_o),
    .port_o     (port_w),
    .lr_ofs_o   (lr_ofs),
    .ctr_ofs_o  (ctr_ofs),
    .br_ofs_o   (br_ofs),
    .n_taken_o  (n_taken_o),
    .n_other_o  (n_other_o),
    .n_lr_o     (alloc_lr_o),
    .n_ctr_o    (alloc_ctr_o),
    .n_br_o     (n_br)
  );

  // Rename read ports, filled from dispatched slots
  always_comb begin
    rd_vld_o = '0;
    rd_tag_o = '0;
    for (int k = 0; k < DISP_W; k++) begin
      for (int c = 0; c < NCLS; c++) begin
        if (disp_o[k] && need[k][c] && int'(port_w[k][c]) < RD_PORTS) begin
          rd_vld_o[c][port_w[k][c]] = 1'b1;
          rd_tag_o[c][port_w[k][c]] = map_tag_i[k][c];
        end
      end
    end
  end

  sreg_wrap_ctr #(.W(TAG_W), .ADV_W(CNT_W)) i_lr_head (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(alloc_lr_o), .val_o(lr_head)
  );
  sreg_wrap_ctr #(.W(TAG_W), .ADV_W(CNT_W)) i_ctr_head (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(alloc_ctr_o), .val_o(ctr_head)
  );
  sreg_wrap_ctr #(.W(BCNT_W), .ADV_W(CNT_W)) i_bcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(n_br), .val_o(bcnt_head)
  );

  // Checks
  for (genvar k = 0; k < DISP_W; k++) begin : g_chk
    a_r6_disp_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_o[k] |-> slot_vld_i[k]);
    if (k > 0) begin : g_ord
      a_r6_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disp_o[k] |-> (disp_o[k-1] || !slot_vld_i[k-1]));
    end
    for (genvar c = 0; c < NCLS; c++) begin : g_c
      a_r1_arch_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arch_rd_o[k][c] |-> !map_live_i[k][c]);
      a_r2_port_carries_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (disp_o[k] && src_mode_o[k][c] == 2'(SRC_RBUF)) |->
          (rd_vld_o[c][src_port_o[k][c]] &&
           rd_tag_o[c][src_port_o[k][c]] == map_tag_i[k][c]));
      a_r3_wait_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_mode_o[k][c] == 2'(SRC_WAIT)) |-> !arch_rd_o[k][c]);
    end
  end

  a_r9_lr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_lr_o <= free_lr_i);
  a_r9_ctr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ctr_o <= free_ctr_i);
  a_r7_lr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_lr_o == '0) |=> $stable(dst_lr_tag_o[0]));
  a_r10_bcnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_taken_o == '0 && n_other_o == '0) |=> $stable(bcnt_o[0]));
endmodule

// File: tb/test_sreg_dispatch.sv
module test_sreg_dispatch;
  localparam int W = 2, P = 1, TW = 3, RW = 5, BW = 4, SW = 10, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] slot_vld, slot_taken, wr_lr, wr_ctr, rob_vld;
  logic [W-1:0][1:0] slot_kind;
  logic [W-1:0][2:0] src_use, map_live, map_done;
  logic [W-1:0][SW-1:0] spr_num;
  logic [W-1:0][RW-1:0] rob_idx;
  logic [W-1:0][2:0][TW-1:0] map_tag;
  logic [CW-1:0] free_lr, free_ctr;
  logic [W-1:0] disp, arch_dummy, dst_lr_vld, dst_ctr_vld, itag_vld;
  logic [W-1:0][2:0][1:0] src_mode;
  logic [W-1:0][2:0][TW-1:0] src_tag;
  logic [W-1:0][2:0][0:0] src_port;
  logic [W-1:0][2:0] arch_rd;
  logic [2:0][P-1:0] rd_vld;
  logic [2:0][P-1:0][TW-1:0] rd_tag;
  logic [W-1:0][TW-1:0] dst_lr_tag, dst_ctr_tag;
  logic [W-1:0][RW-1:0] itag;
  logic [W-1:0][BW-1:0] bcnt;
  logic [CW-1:0] n_taken, n_other, alloc_lr, alloc_ctr;

  int n_chk = 0, n_fail = 0;
  int exp_bcnt = 0, exp_lr = 0, exp_ctr = 0;

  always #10 clk = ~clk;

  sreg_dispatch i_sreg_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .slot_vld_i(slot_vld), .slot_kind_i(slot_kind),
    .slot_taken_i(slot_taken), .src_use_i(src_use), .wr_lr_i(wr_lr), .wr_ctr_i(wr_ctr),
    .spr_num_i(spr_num), .rob_vld_i(rob_vld), .rob_idx_i(rob_idx),
    .map_live_i(map_live), .map_tag_i(map_tag), .map_done_i(map_done),
    .free_lr_i(free_lr), .free_ctr_i(free_ctr), .disp_o(disp), .src_mode_o(src_mode),
    .src_tag_o(src_tag), .src_port_o(src_port), .arch_rd_o(arch_rd),
    .rd_vld_o(rd_vld), .rd_tag_o(rd_tag), .dst_lr_vld_o(dst_lr_vld),
    .dst_lr_tag_o(dst_lr_tag), .dst_ctr_vld_o(dst_ctr_vld), .dst_ctr_tag_o(dst_ctr_tag),
    .itag_vld_o(itag_vld), .itag_o(itag), .bcnt_o(bcnt), .n_taken_o(n_taken),
    .n_other_o(n_other), .alloc_lr_o(alloc_lr), .alloc_ctr_o(alloc_ctr)
  );
  assign arch_dummy = '0;

  // {kind[11:10], use[9], live[8], done[7], tag[6:4], mode[3:2], arch[1], rd[0]}
  localparam logic [11:0] VEC [8] = '{
    {2'd1, 1'b1, 1'b0, 1'b0, 3'd0, 2'd1, 1'b1, 1'b0},  // R1 arch
    {2'd1, 1'b1, 1'b1, 1'b1, 3'd5, 2'd2, 1'b0, 1'b1},  // R2 rename read
    {2'd1, 1'b1, 1'b1, 1'b0, 3'd3, 2'd3, 1'b0, 1'b0},  // R3 wait
    {2'd1, 1'b0, 1'b1, 1'b1, 3'd6, 2'd0, 1'b0, 1'b0},  // R4 unused
    {2'd2, 1'b1, 1'b1, 1'b1, 3'd2, 2'd0, 1'b0, 1'b0},  // R4 move-to-special
    {2'd0, 1'b1, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0},  // R4 other
    {2'd1, 1'b1, 1'b1, 1'b1, 3'd7, 2'd2, 1'b0, 1'b1},  // R2 rename read
    {2'd1, 1'b1, 1'b0, 1'b1, 3'd4, 2'd1, 1'b1, 1'b0}   // R1 done ignored
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    slot_vld = '0; slot_kind = '0; slot_taken = '0; src_use = '0; wr_lr = '0;
    wr_ctr = '0; spr_num = '0; rob_vld = '0; rob_idx = '0; map_live = '0;
    map_tag = '0; map_done = '0; free_lr = 2'd3; free_ctr = 2'd3;
  endtask

  task automatic tick(input int br_n, input int lr_n, input int ctr_n);
    @(posedge clk);
    exp_bcnt = (exp_bcnt + br_n) % 16;
    exp_lr   = (exp_lr + lr_n) % 8;
    exp_ctr  = (exp_ctr + ctr_n) % 8;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_in();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R13/R7/R10: first allocation after reset
    slot_vld = 2'b11; slot_kind[0] = 2'd1; slot_kind[1] = 2'd1;
    wr_lr = 2'b11; wr_ctr = 2'b01; free_lr = 2'd2; free_ctr = 2'd2;
    #2;
    chk("R13", "bcnt slot0", int'(bcnt[0]), 0);
    chk("R13", "lr tag slot0", int'(dst_lr_tag[0]), 0);
    chk("R7", "lr tag slot1", int'(dst_lr_tag[1]), 1);
    chk("R7", "ctr vld slot1", int'(dst_ctr_vld[1]), 0);
    chk("R7", "alloc lr", int'(alloc_lr), 2);
    chk("R10", "bcnt slot1", int'(bcnt[1]), 1);
    chk("R11", "n_other", int'(n_other), 2);
    tick(2, 2, 1);

    // Table walk over source resolution, slot 0, class cycling
    for (int i = 0; i < 8; i++) begin
      int c;
      c = i % 3;
      clear_in();
      slot_vld[0] = 1'b1;
      slot_kind[0] = VEC[i][11:10];
      src_use[0][c] = VEC[i][9];
      map_live[0][c] = VEC[i][8];
      map_done[0][c] = VEC[i][7];
      map_tag[0][c] = VEC[i][6:4];
      #2;
      chk("R1-R4", "src mode", int'(src_mode[0][c]), int'(VEC[i][3:2]));
      chk("R1", "arch read", int'(arch_rd[0][c]), int'(VEC[i][1]));
      chk("R2", "port valid", int'(rd_vld[c][0]), int'(VEC[i][0]));
      if (VEC[i][0]) chk("R2", "port tag", int'(rd_tag[c][0]), int'(VEC[i][6:4]));
      if (VEC[i][3:2] == 2'd3) chk("R3", "kept tag", int'(src_tag[0][c]), int'(VEC[i][6:4]));
      chk("R4", "dispatched", int'(disp[0]), 1);
      chk("R10", "bcnt", int'(bcnt[0]), exp_bcnt);
      tick((VEC[i][11:10] == 2'd1) ? 1 : 0, 0, 0);
    end

    // R6: two link reads, one port
    clear_in();
    slot_vld = 2'b11; slot_kind[0] = 2'd1; slot_kind[1] = 2'd1;
    src_use[0][1] = 1'b1; map_live[0][1] = 1'b1; map_done[0][1] = 1'b1; map_tag[0][1] = 3'd1;
    src_use[1][1] = 1'b1; map_live[1][1] = 1'b1; map_done[1][1] = 1'b1; map_tag[1][1] = 3'd2;
    #2;
    chk("R6", "slot0 disp", int'(disp[0]), 1);
    chk("R6", "slot1 stalled", int'(disp[1]), 0);
    chk("R6", "lr port tag", int'(rd_tag[1][0]), 1);
    tick(1, 0, 0);

    // R5: different classes share nothing
    clear_in();
    slot_vld = 2'b11; slot_kind[0] = 2'd1; slot_kind[1] = 2'd1;
    src_use[0][0] = 1'b1; map_live[0][0] = 1'b1; map_done[0][0] = 1'b1; map_tag[0][0] = 3'd3;
    src_use[1][1] = 1'b1; map_live[1][1] = 1'b1; map_done[1][1] = 1'b1; map_tag[1][1] = 3'd4;
    #2;
    chk("R5", "both disp", int'(disp), 3);
    chk("R5", "cr port tag", int'(rd_tag[0][0]), 3);
    chk("R5", "lr port tag", int'(rd_tag[1][0]), 4);
    chk("R5", "slot1 port idx", int'(src_port[1][1]), 0);
    tick(2, 0, 0);

    // R6: invalid slot blocks nothing
    clear_in();
    slot_vld = 2'b10; slot_kind[0] = 2'd1; src_use[0][0] = 1'b1;
    #2;
    chk("R6", "gap slot1 disp", int'(disp[1]), 1);
    chk("R6", "gap no arch read", int'(arch_rd[0][0]), 0);
    chk("R10", "non-branch bcnt", int'(bcnt[1]), exp_bcnt);
    tick(0, 0, 0);

    // R9: count pool empty stalls both
    clear_in();
    slot_vld = 2'b11; slot_kind[0] = 2'd2; slot_kind[1] = 2'd2;
    spr_num[0] = 10'd9; spr_num[1] = 10'd8; free_ctr = 2'd0; free_lr = 2'd2;
    #2;
    chk("R9", "stall disp", int'(disp), 0);
    chk("R9", "no lr alloc", int'(alloc_lr), 0);
    tick(0, 0, 0);
    chk("R9", "lr head held", int'(dst_lr_tag[0]), exp_lr);
    free_ctr = 2'd1;
    #2;
    chk("R9", "released disp", int'(disp), 3);
    chk("R8", "ctr tag slot0", int'(dst_ctr_tag[0]), exp_ctr);
    chk("R8", "lr tag slot1", int'(dst_lr_tag[1]), exp_lr);
    chk("R8", "no lr slot0", int'(dst_lr_vld[0]), 0);
    chk("R8", "no ctr slot1", int'(dst_ctr_vld[1]), 0);
    tick(0, 1, 1);

    // R8: register number outside 8/9
    clear_in();
    slot_vld = 2'b01; slot_kind[0] = 2'd2; spr_num[0] = 10'd10;
    #2;
    chk("R8", "no lr alloc", int'(dst_lr_vld[0]) + int'(alloc_lr), 0);
    chk("R8", "no ctr alloc", int'(dst_ctr_vld[0]) + int'(alloc_ctr), 0);
    tick(0, 0, 0);

    // R11/R12: taken vs not taken, tag pass-through
    clear_in();
    slot_vld = 2'b11; slot_kind[0] = 2'd1; slot_kind[1] = 2'd1; slot_taken = 2'b01;
    rob_vld = 2'b01; rob_idx[0] = 5'd17; rob_idx[1] = 5'd9;
    #2;
    chk("R11", "n_taken", int'(n_taken), 1);
    chk("R11", "n_other", int'(n_other), 1);
    chk("R12", "itag vld", int'(itag_vld), 1);
    chk("R12", "itag slot0", int'(itag[0]), 17);
    chk("R10", "bcnt slot1", int'(bcnt[1]), (exp_bcnt + 1) % 16);
    tick(2, 0, 0);

    clear_in();
    slot_vld = 2'b01;
    #2;
    chk("R10", "bcnt advanced", int'(bcnt[0]), exp_bcnt);

    // R13: second reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    slot_kind[0] = 2'd1; wr_lr[0] = 1'b1;
    #2;
    chk("R13", "bcnt after reset", int'(bcnt[0]), 0);
    chk("R13", "lr tag after reset", int'(dst_lr_tag[0]), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule